// File: doc/BRIEF.md
# Parallel RGB Display Output Formatter

This block sits between a video timing generator and the pins of a parallel display panel. Each clock it accepts one 24-bit pixel, given as red in the top byte, green in the middle byte and blue in the low byte, together with horizontal sync, vertical sync and a data-enable strobe. It reorders the three colour channels, packs them into one of several bus layouts, and drives the result on a 24-line data bus. The sync and enable outputs are conditioned separately: each can be inverted, launched on the falling clock edge, or forced to its idle level.

Software controls the block through one 17-bit control word held in a small register file. The control address reads back the stored word. Every other address returns a fixed identification value, so a driver can confirm that the block is present. When the global enable bit is clear, every output is held low. When software sets the enable bit after it was clear, the output pipeline stays cleared for one extra cycle before it starts to carry pixels.

Top module: `rgb_bus_formatter`

## Requirements
- R1: A write to the control address stores write-data bits 16:0 in the control word, and the change takes effect at that clock edge. A read at the control address returns the stored word with bits 31:17 as zero. After reset the word is all zeros.
- R2: A read at any address other than the control address returns 0x00647069.
- R3: Control bits 15:14 choose the channel order (first, second, third): 0 is R,G,B; 1 is B,G,R; 2 is G,R,B; 3 is B,R,G.
- R4: Control bits 13:11 choose the bus layout, using the top bits of each reordered channel a, b and c. Code 0 gives all zeros. Code 1 gives a5 at 15:11, b6 at 10:5 and c5 at 4:0. Code 2 gives a5 at 20:16, b6 at 13:8 and c5 at 4:0. Code 3 gives a5 at 21:17, b6 at 13:8 and c5 at 5:1. Code 4 gives a6 at 17:12, b6 at 11:6 and c6 at 5:0. Code 5 gives a6 at 21:16, b6 at 13:8 and c6 at 5:0. Code 6 gives a at 23:16, b at 15:8 and c at 7:0. Code 7 gives all zeros. Every bit not named is zero.
- R5: The data bus shows the packed pixel one clock after the input is sampled. It is zero for any pixel whose input data-enable was low.
- R6: Bits 9, 8 and 7 invert the hsync, vsync and data-enable outputs. Bit 10 drives the clock-invert flag output high while the block is enabled.
- R7: Bits 6, 5 and 4 launch hsync, vsync and data-enable from a falling-edge stage, which delays that output by half a cycle after its rising-edge value.
- R8: Bits 3, 2 and 1 force hsync, vsync and data-enable to their idle level. The idle level is the value of that signal's invert bit.
- R9: With bit 16 set, the data-enable output carries composite sync (hsync OR vsync) in place of data-enable. The data bus is still gated by the real data-enable input.
- R10: With bit 0 clear, all data, sync and flag outputs are low. At the first clock edge after bit 0 goes from 0 to 1, the pipeline is cleared again. It captures pixels from the edge after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from the address |
| pix_rgb | input | 3*CH_W | Input pixel, red high, blue low |
| pix_hs | input | 1 | Input horizontal sync |
| pix_vs | input | 1 | Input vertical sync |
| pix_de | input | 1 | Input data enable |
| bus_data | output | 3*CH_W | Packed display data |
| bus_hs | output | 1 | Conditioned horizontal sync |
| bus_vs | output | 1 | Conditioned vertical sync |
| bus_de | output | 1 | Conditioned data enable or composite sync |
| bus_clk_inv | output | 1 | Request to the pad logic to invert the pixel clock |

## Verification
Data and rising-launched syncs are due one clock after the inputs are sampled. A falling-launched sync is due half a cycle later still. Register reads are combinational, and a control write affects outputs from the edge after the write edge. After enable goes from 0 to 1, the first pixel appears two edges later. The bench drives inputs 3 ns after each rising edge and compares every output 2 ns after the edge. At that point the falling-edge stage still holds the previous cycle's value, which separates the two launch modes. A behavioural model, advanced on the same edges, supplies the expected values each cycle.

// File: rtl/rgbfmt_pkg.sv
package rgbfmt_pkg;

    localparam int          CTRL_W  = 17;
    localparam logic [31:0] ID_WORD = 32'h0064_7069;

    // Field positions are software visible; order is MSB first.
    typedef struct packed {
        logic       de_csync;
        logic [1:0] order;
        logic [2:0] fmt;
        logic       inv_clk;
        logic       inv_hs;
        logic       inv_vs;
        logic       inv_de;
        logic       fall_hs;
        logic       fall_vs;
        logic       fall_de;
        logic       dis_hs;
        logic       dis_vs;
        logic       dis_de;
        logic       en;
    } ctrl_t;

    typedef enum logic [1:0] {
        ORD_RGB = 2'd0,
        ORD_BGR = 2'd1,
        ORD_GRB = 2'd2,
        ORD_BRG = 2'd3
    } order_e;

    typedef enum logic [2:0] {
        FMT_BLANK      = 3'd0,
        FMT_565_LOW    = 3'd1,
        FMT_565_SPREAD = 3'd2,
        FMT_565_SHIFT  = 3'd3,
        FMT_666_LOW    = 3'd4,
        FMT_666_SPREAD = 3'd5,
        FMT_888        = 3'd6,
        FMT_RSVD       = 3'd7
    } fmt_e;

endpackage

// File: rtl/rgbfmt_regs.sv
module rgbfmt_regs
    import rgbfmt_pkg::*;
#(
    parameter int                ADDR_W    = 4,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output ctrl_t             ctrl
);

    localparam int PAD_W = 32 - CTRL_W;

    ctrl_t ctrl_d, ctrl_q;
    logic  hit;
    logic  unused_wdata_hi;

    assign hit             = (addr == CTRL_ADDR);
    assign unused_wdata_hi = ^wdata[31:CTRL_W];

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_en && hit) begin
            ctrl_d = ctrl_t'(wdata[CTRL_W-1:0]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign rdata = hit ? {{PAD_W{1'b0}}, ctrl_q} : ID_WORD;
    assign ctrl  = ctrl_q;

endmodule

// File: rtl/rgbfmt_pack.sv
module rgbfmt_pack
    import rgbfmt_pkg::*;
#(
    parameter int CH_W = 8
) (
    input  logic [1:0]        order,
    input  logic [2:0]        fmt,
    input  logic [3*CH_W-1:0] pix,
    output logic [3*CH_W-1:0] bus
);

    localparam int BUS_W = 3 * CH_W;

    logic [CH_W-1:0] red, grn, blu;
    logic [CH_W-1:0] ch_a, ch_b, ch_c;
    logic [4:0]      a5, c5;
    logic [5:0]      a6, b6, c6;

    assign red = pix[3*CH_W-1 -: CH_W];
    assign grn = pix[2*CH_W-1 -: CH_W];
    assign blu = pix[CH_W-1   -: CH_W];

    always_comb begin
        case (order_e'(order))
            ORD_RGB: begin ch_a = red; ch_b = grn; ch_c = blu; end
            ORD_BGR: begin ch_a = blu; ch_b = grn; ch_c = red; end
            ORD_GRB: begin ch_a = grn; ch_b = red; ch_c = blu; end
            default: begin ch_a = blu; ch_b = red; ch_c = grn; end
        endcase
    end

    assign a5 = ch_a[CH_W-1 -: 5];
    assign c5 = ch_c[CH_W-1 -: 5];
    assign a6 = ch_a[CH_W-1 -: 6];
    assign b6 = ch_b[CH_W-1 -: 6];
    assign c6 = ch_c[CH_W-1 -: 6];

    always_comb begin
        case (fmt_e'(fmt))
            FMT_565_LOW:    bus = BUS_W'({a5, b6, c5});
            FMT_565_SPREAD: bus = BUS_W'({3'b0, a5, 2'b0, b6, 3'b0, c5});
            FMT_565_SHIFT:  bus = BUS_W'({2'b0, a5, 3'b0, b6, 2'b0, c5, 1'b0});
            FMT_666_LOW:    bus = BUS_W'({a6, b6, c6});
            FMT_666_SPREAD: bus = BUS_W'({2'b0, a6, 2'b0, b6, 2'b0, c6});
            FMT_888:        bus = {ch_a, ch_b, ch_c};
            default:        bus = '0;
        endcase
    end

endmodule

// File: rtl/rgbfmt_launch.sv
module rgbfmt_launch (
    input  logic clk,
    input  logic rst_n,
    input  logic rise_in,
    input  logic fall_sel,
    output logic out
);

    logic fall_d, fall_q;

    always_comb begin
        fall_d = rise_in;
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fall_q <= 1'b0;
        end else begin
            fall_q <= fall_d;
        end
    end

    assign out = fall_sel ? fall_q : rise_in;

endmodule

// File: rtl/rgb_bus_formatter.sv
module rgb_bus_formatter
    import rgbfmt_pkg::*;
#(
    parameter int                ADDR_W    = 4,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = '0,
    parameter int                CH_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [3*CH_W-1:0] pix_rgb,
    input  logic              pix_hs,
    input  logic              pix_vs,
    input  logic              pix_de,
    output logic [3*CH_W-1:0] bus_data,
    output logic              bus_hs,
    output logic              bus_vs,
    output logic              bus_de,
    output logic              bus_clk_inv
);

    localparam int BUS_W    = 3 * CH_W;
    localparam int NUM_SYNC = 3;

    typedef struct packed {
        logic [BUS_W-1:0] data;
        logic             hs;
        logic             vs;
        logic             de;
        logic             prev_en;
    } pipe_t;

    ctrl_t            ctrl_q;
    pipe_t            pipe_d, pipe_q;
    logic [BUS_W-1:0] packed_pix;
    logic             live;
    logic             de_src;
    logic [NUM_SYNC-1:0] rise_sync, fall_sel, out_sync;

    rgbfmt_regs #(
        .ADDR_W    (ADDR_W),
        .CTRL_ADDR (CTRL_ADDR)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (reg_wr_en),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .ctrl  (ctrl_q)
    );

    rgbfmt_pack #(
        .CH_W (CH_W)
    ) u_pack (
        .order (ctrl_q.order),
        .fmt   (ctrl_q.fmt),
        .pix   (pix_rgb),
        .bus   (packed_pix)
    );

    // Pipeline runs only after a full cycle of enable (start-up clear).
    assign live   = ctrl_q.en & pipe_q.prev_en;
    assign de_src = ctrl_q.de_csync ? (pix_hs | pix_vs) : pix_de;

    always_comb begin
        pipe_d         = '0;
        pipe_d.prev_en = ctrl_q.en;
        if (live) begin
            pipe_d.data = pix_de ? packed_pix : '0;
            pipe_d.hs   = (pix_hs & ~ctrl_q.dis_hs) ^ ctrl_q.inv_hs;
            pipe_d.vs   = (pix_vs & ~ctrl_q.dis_vs) ^ ctrl_q.inv_vs;
            pipe_d.de   = (de_src & ~ctrl_q.dis_de) ^ ctrl_q.inv_de;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign rise_sync = {pipe_q.hs, pipe_q.vs, pipe_q.de};
    assign fall_sel  = {ctrl_q.fall_hs, ctrl_q.fall_vs, ctrl_q.fall_de};

    for (genvar i = 0; i < NUM_SYNC; i++) begin : g_sync
        rgbfmt_launch u_launch (
            .clk      (clk),
            .rst_n    (rst_n),
            .rise_in  (rise_sync[i]),
            .fall_sel (fall_sel[i]),
            .out      (out_sync[i])
        );
    end

    assign bus_data    = pipe_q.data;
    assign bus_hs      = out_sync[2];
    assign bus_vs      = out_sync[1];
    assign bus_de      = out_sync[0];
    assign bus_clk_inv = ctrl_q.en & ctrl_q.inv_clk;

endmodule

// File: rtl/rgbfmt_checker.sv
module rgbfmt_checker #(
    parameter int                ADDR_W    = 4,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = '0,
    parameter int                BUS_W     = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr_en,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [31:0]       reg_rdata,
    input logic              pix_de,
    input logic [BUS_W-1:0]  bus_data,
    input logic              bus_hs,
    input logic [16:0]       ctrl,
    input logic              prev_en
);

    // R1: upper readback bits of the control word are always zero
    assert_ctrl_hi_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == CTRL_ADDR) |-> (reg_rdata[31:17] == 15'd0));

    // R2: identification value at all other addresses
    assert_id_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr != CTRL_ADDR) |-> (reg_rdata == 32'h0064_7069));

    // R5: blanked pixel yields a zero bus one cycle later
    assert_blank_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_de |=> (bus_data == '0));

    // R8: disabled, rising-launched hsync sits at its idle level
    assert_hs_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[0] && prev_en && ctrl[3] && !ctrl[6] && !reg_wr_en)
        |=> (bus_hs == ctrl[9]));

    // R10: disabled block drives a zero bus
    assert_off_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl[0] |=> (bus_data == '0));

    // R10: first edge after enabling clears the pipeline
    assert_start_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[0] && !prev_en) |=> (bus_data == '0));

endmodule

bind rgb_bus_formatter rgbfmt_checker #(
    .ADDR_W    (ADDR_W),
    .CTRL_ADDR (CTRL_ADDR),
    .BUS_W     (3 * CH_W)
) u_rgbfmt_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr_en (reg_wr_en),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .pix_de    (pix_de),
    .bus_data  (bus_data),
    .bus_hs    (bus_hs),
    .ctrl      (ctrl_q),
    .prev_en   (pipe_q.prev_en)
);

// File: tb/test_rgb_bus_formatter.sv
`timescale 1ns/1ps
module test_rgb_bus_formatter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [23:0] pix_rgb = '0;
    logic        pix_hs = 1'b0, pix_vs = 1'b0, pix_de = 1'b0;
    logic [23:0] bus_data;
    logic        bus_hs, bus_vs, bus_de, bus_clk_inv;

    int checks = 0;
    int fails  = 0;
    bit cmp_on = 1'b0;

    always #5 clk = ~clk;

    rgb_bus_formatter i_rgb_bus_formatter (
        .clk (clk), .rst_n (rst_n),
        .reg_wr_en (reg_wr_en), .reg_addr (reg_addr),
        .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
        .pix_rgb (pix_rgb), .pix_hs (pix_hs), .pix_vs (pix_vs), .pix_de (pix_de),
        .bus_data (bus_data), .bus_hs (bus_hs), .bus_vs (bus_vs),
        .bus_de (bus_de), .bus_clk_inv (bus_clk_inv)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference ----------------
    function automatic logic [23:0] ref_pack(input logic [1:0] ord, input logic [2:0] f,
                                              input logic [23:0] p);
        int r, g, b, a, m, c;
        int res;
        r = p[23:16]; g = p[15:8]; b = p[7:0];
        case (ord)
            2'd0: begin a = r; m = g; c = b; end
            2'd1: begin a = b; m = g; c = r; end
            2'd2: begin a = g; m = r; c = b; end
            default: begin a = b; m = r; c = g; end
        endcase
        case (f)
            3'd1: res = ((a >> 3) << 11) | ((m >> 2) << 5) | (c >> 3);
            3'd2: res = ((a >> 3) << 16) | ((m >> 2) << 8) | (c >> 3);
            3'd3: res = ((a >> 3) << 17) | ((m >> 2) << 8) | ((c >> 3) << 1);
            3'd4: res = ((a >> 2) << 12) | ((m >> 2) << 6) | (c >> 2);
            3'd5: res = ((a >> 2) << 16) | ((m >> 2) << 8) | (c >> 2);
            3'd6: res = (a << 16) | (m << 8) | c;
            default: res = 0;
        endcase
        return res[23:0];
    endfunction

    logic [16:0] m_ctrl;
    bit          m_was_on;
    logic [23:0] m_data;
    bit          m_hs, m_vs, m_de;
    bit          f_hs, f_vs, f_de;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ctrl = '0; m_was_on = 0;
            m_data = '0; m_hs = 0; m_vs = 0; m_de = 0;
        end else begin
            if (m_ctrl[0] && m_was_on) begin
                m_data = pix_de ? ref_pack(m_ctrl[15:14], m_ctrl[13:11], pix_rgb) : 24'd0;
                m_hs = m_ctrl[3] ? m_ctrl[9] : (pix_hs != m_ctrl[9]);
                m_vs = m_ctrl[2] ? m_ctrl[8] : (pix_vs != m_ctrl[8]);
                m_de = m_ctrl[1] ? m_ctrl[7] :
                       ((m_ctrl[16] ? (pix_hs || pix_vs) : pix_de) != m_ctrl[7]);
            end else begin
                m_data = '0; m_hs = 0; m_vs = 0; m_de = 0;
            end
            m_was_on = m_ctrl[0];
            if (reg_wr_en && reg_addr == 4'd0) m_ctrl = reg_wdata[16:0];
        end
    end

    always @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_hs = 0; f_vs = 0; f_de = 0;
        end else begin
            f_hs = m_hs; f_vs = m_vs; f_de = m_de;
        end
    end

    always @(posedge clk) begin
        #2;
        if (rst_n && cmp_on) begin
            chk("R3 R4 R5 R10 data", bus_data, m_data);
            chk("R6 R7 R8 hsync", bus_hs, m_ctrl[6] ? f_hs : m_hs);
            chk("R6 R7 R8 vsync", bus_vs, m_ctrl[5] ? f_vs : m_vs);
            chk("R6 R7 R8 R9 de", bus_de, m_ctrl[4] ? f_de : m_de);
            chk("R6 clk flag", bus_clk_inv, m_ctrl[0] & m_ctrl[10]);
        end
    end

    // ---------------- stimulus ----------------
    task automatic wr(input logic [31:0] v);
        @(posedge clk); #3;
        reg_wr_en = 1'b1; reg_addr = 4'd0; reg_wdata = v;
        @(posedge clk); #3;
        reg_wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string tag);
        @(posedge clk); #3;
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
        reg_addr = 4'd0;
    endtask

    task automatic run(input int n);
        repeat (n) begin
            @(posedge clk); #3;
            pix_rgb = 24'($urandom);
            pix_hs  = 1'($urandom);
            pix_vs  = 1'($urandom);
            pix_de  = ($urandom % 4) != 0;
        end
    endtask

    bit finished = 0;

    initial begin
        #1_500_000;
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual hang expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #3 rst_n = 1'b1;
        @(posedge clk); #2;
        // reset state
        chk("R10 reset data", bus_data, 24'd0);
        chk("R10 reset syncs", {bus_hs, bus_vs, bus_de, bus_clk_inv}, 4'd0);
        rd_chk(4'd0, 32'd0, "R1 reset word");
        rd_chk(4'd3, 32'h0064_7069, "R2 id at 3");
        rd_chk(4'd15, 32'h0064_7069, "R2 id at 15");
        wr(32'hFFFF_FFFF);
        rd_chk(4'd0, 32'h0001_FFFF, "R1 upper bits dropped");
        wr(32'h0000_0000);
        cmp_on = 1'b1;
        run(10);

        // R10 start-up: hold a fixed visible pixel, then enable
        @(posedge clk); #3;
        pix_rgb = 24'hA5_3C_96; pix_de = 1'b1; pix_hs = 1'b0; pix_vs = 1'b0;
        wr(32'h0000_3001);  // order 0, fmt 6, enabled
        @(posedge clk); #2;
        chk("R10 first edge cleared", bus_data, 24'd0);
        @(posedge clk); #2;
        chk("R10 second edge shows pixel", bus_data, 24'hA5_3C_96);

        // R3 R4: every order and layout
        for (int o = 0; o < 4; o++) begin
            for (int f = 0; f < 8; f++) begin
                wr(32'((o << 14) | (f << 11) | 1));
                run(20);
            end
        end

        // R6 R7 R8: sync conditioning bits 1..10
        for (int k = 0; k < 1024; k++) begin
            wr(32'((k << 1) | (3 << 14) | (6 << 11) | 1));
            run(5);
        end

        // R9: composite sync on the de line, with and without inversion/falling
        wr(32'h0001_3001);
        run(40);
        wr(32'h0001_3091);
        run(40);

        // R10: disable, then re-enable with random traffic
        wr(32'h0000_3000);
        run(15);
        wr(32'h0000_3001);
        run(15);

        cmp_on = 1'b0;
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule